// File: doc/BRIEF.md
# Indexed-Colour Palette Table

This block holds the colour table of an indexed-colour display controller. A host loads it through a byte-wide register pair. One register, the index port, selects a table entry. The other, the component port, receives three bytes in a row: red, green and blue. A hidden phase counter tracks which component is due next. The entry is written only when the blue byte arrives. The index then steps to the next entry, so a host can stream consecutive triplets after a single index write.

The pixel pipeline drives an 8-bit pixel index on a separate read port. One clock later it receives a 12-bit RGB word, with red in bits 11:8, green in bits 7:4 and blue in bits 3:0. Each component keeps four bits. The host side cannot read the table back.

Top module: `palette_lut`

## Requirements
- R1: After reset every table entry holds 0, pixRgb is 0, the write index is 0 and the next component byte is red.
- R2: A host write with hostSel=0 loads the write index from hostData and makes the next component byte red.
- R3: Host writes with hostSel=1 carry red, green and blue in that order. The entry at the write index then reads back as {red[7:4], green[7:4], blue[7:4]}, with red in pixRgb[11:8], green in [7:4] and blue in [3:0].
- R4: Only the upper nibble of each component byte is kept. The lower nibble has no effect on the stored entry.
- R5: An entry keeps its old value until the blue byte of its triplet has been written.
- R6: After each blue byte the write index increments by one, wrapping from 255 to 0, and the next component byte is red again.
- R7: An index write in the middle of a triplet discards the red and green bytes already given. The next component byte is red for the new index.
- R8: pixRgb shows the entry addressed by pixIdx at the previous clock edge (one-cycle latency).
- R9: When a blue byte and a pixel read hit the same entry at the same edge, the read returns the old value. The new value appears on the read after that.
- R10: Cycles with hostWe=0 change neither the table, the write index nor the component phase, whatever hostSel and hostData hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host write strobe, one byte per cycle |
| hostSel | input | 1 | 0 = index port, 1 = component port |
| hostData | input | 8 | Host write byte |
| pixIdx | input | 8 | Pixel index to look up |
| pixRgb | output | 12 | Looked-up colour, red 11:8, green 7:4, blue 3:0 |

## Verification
A blue byte sampled at edge N changes the table at that edge. A read that presents the same index before edge N returns the old entry after edge N. A read presented for edge N+1 returns the new entry. The bench drives every input just after a falling edge and samples pixRgb at the next falling edge, one rising edge later. Writes are checked only through this read path. The expected colour is taken from a bench model that is updated in the same cycle as the blue write.

// File: rtl/palette_lut_pkg.sv
package palette_lut_pkg;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;

  // Strobes from the sequencer to the storage side
  typedef struct packed {
    logic latchRed;
    logic latchGreen;
    logic commit;
  } strobe_t;

endpackage

// File: rtl/palette_lut_ctrl.sv
module palette_lut_ctrl
  import palette_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic             hostSel,
  input  logic [IDX_W-1:0] idxByte,
  output strobe_t          strobe,
  output phase_t           phase,
  output logic [IDX_W-1:0] wrIdx
);

  always_comb begin
    strobe = '0;
    if (hostWe && hostSel) begin
      case (phase)
        PH_RED:   strobe.latchRed   = 1'b1;
        PH_GREEN: strobe.latchGreen = 1'b1;
        PH_BLUE:  strobe.commit     = 1'b1;
        default:  strobe            = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_RED;
      wrIdx <= '0;
    end else if (hostWe) begin
      if (!hostSel) begin
        phase <= PH_RED;
        wrIdx <= idxByte;
      end else begin
        case (phase)
          PH_RED:   phase <= PH_GREEN;
          PH_GREEN: phase <= PH_BLUE;
          PH_BLUE: begin
            phase <= PH_RED;
            wrIdx <= wrIdx + 1'b1;
          end
          default:  phase <= PH_RED;
        endcase
      end
    end
  end

endmodule

// File: rtl/palette_lut_store.sv
module palette_lut_store
  import palette_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [COMP_W-1:0]   compVal,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*COMP_W-1:0] pixRgb
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int RGB_W   = 3 * COMP_W;

  logic [COMP_W-1:0] redHold;
  logic [COMP_W-1:0] greenHold;
  logic [RGB_W-1:0]  table_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      redHold   <= '0;
      greenHold <= '0;
    end else begin
      if (strobe.latchRed)   redHold   <= compVal;
      if (strobe.latchGreen) greenHold <= compVal;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        table_q[e] <= '0;
      else if (strobe.commit && (wrIdx == IDX_W'(e)))
        table_q[e] <= {redHold, greenHold, compVal};
    end
  end

  // Registered read sees the table contents before this edge
  always_ff @(posedge clk) begin
    if (!rstN) pixRgb <= '0;
    else       pixRgb <= table_q[pixIdx];
  end

endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int COMP_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWe,
  input  logic                hostSel,
  input  logic [DATA_W-1:0]   hostData,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*COMP_W-1:0] pixRgb
);

  strobe_t          strobe;
  phase_t           phase;
  logic [IDX_W-1:0] wrIdx;

  palette_lut_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostWe  (hostWe),
    .hostSel (hostSel),
    .idxByte (hostData[IDX_W-1:0]),
    .strobe  (strobe),
    .phase   (phase),
    .wrIdx   (wrIdx)
  );

  palette_lut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrIdx   (wrIdx),
    .compVal (hostData[DATA_W-1 -: COMP_W]),
    .pixIdx  (pixIdx),
    .pixRgb  (pixRgb)
  );

endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk
  import palette_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 8,
  parameter int COMP_W = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                hostWe,
  input logic                hostSel,
  input logic [DATA_W-1:0]   hostData,
  input logic [3*COMP_W-1:0] pixRgb,
  input phase_t              phase,
  input logic [IDX_W-1:0]    wrIdx
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pixRgb == '0 && phase == PH_RED && wrIdx == '0));

  // R2
  index_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && !hostSel) |=> (wrIdx == $past(hostData[IDX_W-1:0]) && phase == PH_RED));

  // R3
  red_then_green_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostSel && phase == PH_RED) |=> (phase == PH_GREEN && $stable(wrIdx)));

  // R3
  green_then_blue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostSel && phase == PH_GREEN) |=> (phase == PH_BLUE && $stable(wrIdx)));

  // R6
  index_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostSel && phase == PH_BLUE) |=> (phase == PH_RED && wrIdx == $past(wrIdx) + 1'b1));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hostWe |=> ($stable(wrIdx) && $stable(phase)));

endmodule

bind palette_lut palette_lut_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .COMP_W(COMP_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostWe   (hostWe),
  .hostSel  (hostSel),
  .hostData (hostData),
  .pixRgb   (pixRgb),
  .phase    (phase),
  .wrIdx    (wrIdx)
);

// File: tb/tb_palette_lut.sv
`timescale 1ns/1ps
module tb_palette_lut;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWe = 1'b0;
  logic       hostSel = 1'b0;
  logic [7:0] hostData = '0;
  logic [7:0] pixIdx = '0;
  logic [11:0] pixRgb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the requirements
  logic [11:0] model [256];
  logic [7:0]  mIdx;
  int          mPhase;
  logic [3:0]  mRed, mGreen;

  always #2 clk = ~clk;

  palette_lut dut (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostData(hostData), .pixIdx(pixIdx), .pixRgb(pixRgb)
  );

  function automatic logic [11:0] packRgb(logic [7:0] r, logic [7:0] g, logic [7:0] b);
    return {r[7:4], g[7:4], b[7:4]};
  endfunction

  task automatic check(string tag, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %03h expected %03h", tag, got, exp);
    end
  endtask

  task automatic modelData(logic [7:0] d);
    case (mPhase)
      0: begin mRed = d[7:4]; mPhase = 1; end
      1: begin mGreen = d[7:4]; mPhase = 2; end
      default: begin
        model[mIdx] = {mRed, mGreen, d[7:4]};
        mIdx = mIdx + 1;
        mPhase = 0;
      end
    endcase
  endtask

  task automatic writeAddr(logic [7:0] a);
    hostWe = 1; hostSel = 0; hostData = a;
    mIdx = a; mPhase = 0;
    @(negedge clk);
    hostWe = 0;
  endtask

  task automatic writeData(logic [7:0] d);
    hostWe = 1; hostSel = 1; hostData = d;
    modelData(d);
    @(negedge clk);
    hostWe = 0;
  endtask

  task automatic readCheck(string tag, logic [7:0] i);
    pixIdx = i;
    @(negedge clk);
    check(tag, pixRgb, model[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) model[i] = '0;
    mIdx = 0; mPhase = 0; mRed = 0; mGreen = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset contents and read output
    check("R1 out", pixRgb, 12'h000);
    readCheck("R1 entry0", 8'd0);
    readCheck("R1 entry255", 8'd255);
    // R1: index 0 and phase red without any index write
    writeData(8'hA1); writeData(8'hB2); writeData(8'hC3);
    readCheck("R1 R3 default index", 8'd0);
    check("R3 packing", model[0], 12'hABC);
    // R2/R3/R4: lower nibble ignored
    writeAddr(8'd40);
    writeData(8'h5F); writeData(8'h60); writeData(8'h7E);
    readCheck("R4 nibble", 8'd40);
    check("R4 value", pixRgb, 12'h567);
    // R6: auto advance and wrap
    writeAddr(8'd255);
    writeData(8'h10); writeData(8'h20); writeData(8'h30);
    writeData(8'h40); writeData(8'h50); writeData(8'h60);
    readCheck("R6 entry255", 8'd255);
    readCheck("R6 wrap entry0", 8'd0);
    check("R6 wrap value", pixRgb, 12'h456);
    // R5: partial triplet leaves entry unchanged
    writeAddr(8'd20);
    writeData(8'h90); writeData(8'h80);
    readCheck("R5 partial", 8'd20);
    check("R5 still zero", pixRgb, 12'h000);
    writeData(8'h70);
    readCheck("R5 complete", 8'd20);
    // R7: index write mid-triplet
    writeAddr(8'd10);
    writeData(8'hF0); writeData(8'hE0);
    writeAddr(8'd11);
    writeData(8'h10); writeData(8'h20); writeData(8'h30);
    readCheck("R7 new entry", 8'd11);
    readCheck("R7 old entry", 8'd10);
    check("R7 old zero", pixRgb, 12'h000);
    // R10: idle cycles with noise do not disturb phase or index
    writeAddr(8'd30);
    writeData(8'h20);
    for (int k = 0; k < 4; k++) begin
      hostWe = 0; hostSel = k[0]; hostData = 8'($urandom);
      @(negedge clk);
    end
    writeData(8'h40); writeData(8'h60);
    readCheck("R10 entry30", 8'd30);
    check("R10 value", pixRgb, 12'h246);
    readCheck("R10 entry31", 8'd31);
    // R8/R9: collision returns old value, then new
    writeAddr(8'd50);
    writeData(8'h30); writeData(8'h30); writeData(8'h30);
    writeAddr(8'd50);
    writeData(8'hC0); writeData(8'hD0);
    hostWe = 1; hostSel = 1; hostData = 8'hE0; pixIdx = 8'd50;
    @(negedge clk);
    hostWe = 0;
    check("R9 old on collision", pixRgb, 12'h333);
    modelData(8'hE0);
    @(negedge clk);
    check("R9 R8 new next cycle", pixRgb, 12'hCDE);
    // R8: back-to-back reads of different entries
    pixIdx = 8'd40;
    @(negedge clk);
    pixIdx = 8'd20;
    check("R8 first", pixRgb, model[40]);
    @(negedge clk);
    check("R8 second", pixRgb, model[20]);
    // random mix of index and component writes
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 9) == 0) writeAddr(8'($urandom));
      else writeData(8'($urandom));
    end
    for (int i = 0; i < 256; i++) readCheck("R3 R6 random", 8'(i));
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule